// File: doc/BRIEF.md
# Four-Channel Serial Converter Interface Model

This block is a synthesizable stand-in for the digital side of a four-channel 10-bit sampling converter with a serial port. A host drives an active-low chip select, a serial clock and a command data line. The model answers on a data output that is released to high impedance whenever it is not selected. Four parallel 10-bit values take the place of the analog inputs. Each conversion lasts 16 serial clocks. The first three clocks are a track window. The model then takes a sample of the addressed input and shifts it out, most significant bit first, on falling clock edges.

The model runs on a fast system clock that oversamples the three serial inputs and detects their edges synchronously. Internally the serial clock is forced high while chip select is high. A chip-select fall with the clock low therefore counts as the first falling edge of the conversion. While select is held low, conversions follow one another every 16 clocks. Each one carries the input address for the next conversion on the command line. The model also reports a power-down state and a track/hold state.

Top module: `adc_serial_model`

## Requirements
- R1: `dout_oe` is 0 whenever `cs_n` is high and 1 while it is low; `dout` is 0 whenever `dout_oe` is 0.
- R2: Counting the falling edges of a conversion from 1 to 16, `hold` is 0 after edges 1 to 3 and 1 after edges 4 to 16.
- R3: While `cs_n` stays low, the falling edge that follows the 16th rising edge starts the next conversion as falling edge 1, and the track/hold pattern of R2 repeats.
- R4: If `sclk` is low when `cs_n` falls, that fall is falling edge 1. If `sclk` is high, the first real `sclk` fall after `cs_n` falls is edge 1.
- R5: `din` is sampled on rising edges 1 to 8 of each conversion, forming a byte MSB first. Byte bits 4:3 select the input for the next conversion: 0 selects `ch_data[9:0]`, 1 selects `[19:10]`, 2 selects `[29:20]` and 3 selects `[39:30]`. All other `din` bits have no effect.
- R6: After reset, the first conversion uses input 0 (`ch_data[9:0]`).
- R7: After falling edges 1 to 4, 15 and 16, `dout` is 0. After falling edge k, for k from 5 to 14, it is bit 14-k of the sample, so the data is straight binary and MSB first.
- R8: The sample is taken from the selected input at falling edge 4. Later changes of `ch_data` in the same conversion do not change the bits shifted out.
- R9: `pdn` is 1 while `cs_n` is high. It is also 1 from falling edge 16 of a conversion until falling edge 1 of the next. Otherwise it is 0.
- R10: Raising `cs_n` aborts the conversion at once. An abort before rising edge 8 leaves the input selection unchanged. The next selected frame starts again at falling edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial command data |
| ch_data | input | 40 | Four 10-bit input values, input 0 in the low bits |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable of the result line (0 means high impedance) |
| pdn | output | 1 | Power-down indicator |
| hold | output | 1 | 1 during hold/convert, 0 during track or idle |

## Verification
Two events can meet in one oversampled cycle: the chip-select rise that aborts a conversion and a serial clock rising edge, here the 8th one, which would latch the next input address. The bench raises `cs_n` and `sclk` on the same system cycle with a command whose address differs from the current one. The abort must win. The next frame's data must come from the previous input, and the frame must restart at falling edge 1. A second coincidence is a chip-select fall with the clock low, which must also count as falling edge 1. It is judged from the track/hold and data timing of that conversion.

// File: rtl/adc_serial_model.sv
module adc_serial_model #(
  parameter int W   = 10,
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           din,
  input  logic [NCH*W-1:0] ch_data,
  output logic           dout,
  output logic           dout_oe,
  output logic           pdn,
  output logic           hold
);
  localparam int CONV     = 16;
  localparam int LEAD     = 4;
  localparam int TRK      = 3;
  localparam int CMD      = 8;
  localparam int ADDR_LSB = 3;
  localparam int CW       = $clog2(CONV + 1);
  localparam int SW       = $clog2(NCH);
  localparam int IW       = $clog2(W);

  logic s_cs, s_sclk, s_din, p_g;
  logic [CW-1:0]  fc;
  logic [CMD-2:0] sr;
  logic [SW-1:0]  ch_sel;
  logic [W-1:0]   smp;
  logic [CW-1:0]  idx;
  logic [CMD-1:0] cmd_byte;

  wire g      = s_sclk | s_cs;
  wire g_fall = p_g & ~g;
  wire g_rise = ~p_g & g & ~s_cs;
  wire in_data = (fc >= CW'(LEAD + 1)) && (fc <= CW'(LEAD + W));

  assign idx      = CW'(LEAD + W) - fc;
  assign cmd_byte = {sr, s_din};
  assign dout_oe  = ~s_cs;
  assign dout     = dout_oe & in_data & smp[idx[IW-1:0]];
  assign pdn      = s_cs | (fc == '0) | (fc == CW'(CONV));
  assign hold     = (fc > CW'(TRK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs   <= 1'b1;
      s_sclk <= 1'b0;
      s_din  <= 1'b0;
      p_g    <= 1'b1;
    end else begin
      s_cs   <= cs_n;
      s_sclk <= sclk;
      s_din  <= din;
      p_g    <= g;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fc <= '0;
    else if (s_cs)
      fc <= '0;
    else if (g_fall)
      fc <= (fc == '0 || fc == CW'(CONV)) ? CW'(1) : fc + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      ch_sel <= '0;
      smp    <= '0;
    end else begin
      if (g_rise && fc >= CW'(1) && fc < CW'(CMD))
        sr <= {sr[CMD-3:0], s_din};
      if (g_rise && fc == CW'(CMD))
        ch_sel <= cmd_byte[ADDR_LSB +: SW];
      if (g_fall && fc == CW'(TRK))
        smp <= ch_data[ch_sel*W +: W];
    end
  end

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) s_cs |=> (fc == '0)); // R10
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !(g_fall && fc == CW'(TRK)) |=> $stable(smp)); // R8
  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) !(g_rise && fc == CW'(CMD)) |=> $stable(ch_sel)); // R5
  AST_PD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) (g_fall && fc == CW'(CONV - 1)) |=> pdn); // R9
  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n) !dout_oe |-> !dout); // R1
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(hold) |-> ($past(fc) == CW'(TRK))); // R2
endmodule

// File: tb/sim_adc_serial_model.sv
module sim_adc_serial_model;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic [39:0] chd = '0;
  logic dout, dout_oe, pdn, hold;

  int n_tests = 0;
  int n_fail = 0;
  int exp_ch = 0;
  bit first_after_reset = 1'b1;
  bit after_abort = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_model u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .ch_data(chd), .dout(dout), .dout_oe(dout_oe), .pdn(pdn), .hold(hold)
  );

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(int pos, logic [9:0] v);
    if (pos >= 5 && pos <= 14) return v[14 - pos];
    return 1'b0;
  endfunction

  function automatic string data_tag(int c, int pos);
    if (pos < 5 || pos > 14) return "R7";
    if (pos >= 7) return "R8";
    if (c == 0 && first_after_reset) return "R6";
    if (c == 0 && after_abort) return "R10";
    return "R5";
  endfunction

  task automatic run_frame(int nconv, bit idle_low, int abort_pos, logic [7:0] abort_cmd);
    sclk = idle_low ? 1'b0 : 1'b1;
    wait_n(H);
    cs_n = 1'b0;
    if (!idle_low) wait_n(H/2);
    for (int c = 0; c < nconv; c++) begin
      logic [7:0] cmd;
      logic [9:0] held;
      int cur;
      string htag;
      cmd = (abort_pos != 0) ? abort_cmd : 8'($urandom);
      cur = exp_ch;
      held = '0;
      for (int pos = 1; pos <= 16; pos++) begin
        if (!(c == 0 && pos == 1 && idle_low)) sclk = 1'b0;
        if (pos == 1) chd = {$urandom, $urandom};
        wait_n(H/2);
        if (pos == 4) held = chd[cur*10 +: 10];
        htag = (c == 0 && pos <= 4) ? "R4" : (c > 0 ? "R3" : "R2");
        chk(htag, {31'd0, hold}, {31'd0, pos >= 4});
        chk(data_tag(c, pos), {31'd0, dout}, {31'd0, exp_bit(pos, held)});
        chk("R9", {31'd0, pdn}, {31'd0, pos == 16});
        chk("R1", {31'd0, dout_oe}, 32'd1);
        if (pos == 6) chd = {$urandom, $urandom};
        wait_n(H/2);
        din = (pos <= 8) ? cmd[8 - pos] : 1'($urandom);
        if (abort_pos != 0 && pos == abort_pos) begin
          sclk = 1'b1;
          cs_n = 1'b1;
          wait_n(4);
          chk("R10", {31'd0, dout_oe}, 32'd0);
          chk("R10", {31'd0, pdn}, 32'd1);
          chk("R10", {31'd0, hold}, 32'd0);
          after_abort = 1'b1;
          first_after_reset = 1'b0;
          wait_n(H);
          return;
        end
        sclk = 1'b1;
        wait_n(H);
        if (pos == 8) exp_ch = int'(cmd[4:3]);
      end
      first_after_reset = 1'b0;
      after_abort = 1'b0;
    end
    cs_n = 1'b1;
    wait_n(4);
    chk("R1", {31'd0, dout_oe}, 32'd0);
    chk("R1", {31'd0, dout}, 32'd0);
    chk("R9", {31'd0, pdn}, 32'd1);
    chk("R2", {31'd0, hold}, 32'd0);
    wait_n(H);
  endtask

  initial begin
    void'($urandom(32'd1357));
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1", {31'd0, dout_oe}, 32'd0);
    chk("R9", {31'd0, pdn}, 32'd1);
    chk("R2", {31'd0, hold}, 32'd0);
    run_frame(1, 1'b1, 0, 8'h00);
    run_frame(2, 1'b0, 0, 8'h00);
    run_frame(3, 1'b1, 0, 8'h00);
    run_frame(1, 1'b0, 8, {3'b111, 2'(exp_ch ^ 1), 3'b101});
    run_frame(2, 1'b0, 0, 8'h00);
    run_frame(1, 1'b1, 5, {3'b010, 2'(exp_ch ^ 2), 3'b011});
    run_frame(1, 1'b1, 0, 8'h00);
    for (int f = 0; f < 20; f++)
      run_frame(1 + int'($urandom_range(2)), 1'($urandom), 0, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule